// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Threshold Flags

This block is a first-in first-out buffer for 18-bit words. The write side and the read side each have their own free-running clock and an enable. The two clocks may be the same net or unrelated. Pointers cross between the domains as Gray codes through two-flop synchronizers. Each flag is computed in the domain of the side it throttles: full, almost-full and half-full on the write clock, and empty and almost-empty on the read clock.

The almost-empty and almost-full thresholds are held in two offset registers that software can rewrite at run time. While the load input is high, write-enabled write-clock edges do not store into the array. They store the low bits of the data word into the offset registers in turn: the empty-side offset first, then the full-side offset, and then back to the empty-side offset. A read-side output enable forces the data port to zero when it is low. The reset input is active-low. It asserts asynchronously and is released synchronously in each clock domain.

Top module: `dcfifo_top`

## Requirements
- R1: Every word written while the buffer is not full and load is low is returned by later reads in the order it was written. The read word appears on the data port after the read-clock edge that performs the read.
- R2: The empty flag is high exactly when the read side sees zero entries. A write becomes visible to it after two further read-clock edges.
- R3: The full flag is high exactly when the write side sees DEPTH entries. It rises on the write edge that fills the last slot.
- R4: A write while full and a read while empty are ignored. Neither pointer moves, and the read data port keeps its previous word.
- R5: The half-full flag is high when the write-side occupancy exceeds DEPTH/2.
- R6: The almost-empty flag is high when the read-side occupancy is at or below the empty-side offset.
- R7: The almost-full flag is high when the free space (DEPTH minus the write-side occupancy) is at or below the full-side offset.
- R8: While load is high, each write-enabled edge stores din[AW:0] into the next offset register, in the order empty-side, full-side, and then wrapping back. No word enters the array. The sequence restarts at the empty-side register whenever load is low.
- R9: After reset the buffer is empty, both offsets equal 7, and the read data port is zero.
- R10: When the output enable is low, the read data port is zero. When it is high, the port shows the last word read.
- R11: With the read clock asynchronous to the write clock, a stream that is throttled only by the full and empty flags arrives complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously |
| wen | input | 1 | Write enable |
| ld | input | 1 | Offset-load mode select |
| din | input | 18 | Write data, or offset value while loading |
| ren | input | 1 | Read enable |
| oe | input | 1 | Output enable for the read data port |
| dout | output | 18 | Read data |
| empty | output | 1 | No entries (read domain) |
| almost_empty | output | 1 | Occupancy at or below the empty-side offset |
| full | output | 1 | All entries used (write domain) |
| almost_full | output | 1 | Free space at or below the full-side offset |
| half_full | output | 1 | Occupancy above half the depth |

## Verification
Each flag has its own latency, and the bench samples each one only when it is due.
- Full, almost-full and half-full change on the write edge that writes. Read data, empty and almost-empty change on the read edge that reads.
- A change made by the other side reaches a flag after two more edges of the flag's own clock.
- In the tied-clock sweeps, the bench drives inputs at falling edges and samples the same-side results at the next falling edge. It waits two further cycles before checking any flag that crosses a domain.
- In the asynchronous run, both sides act only on flags sampled at their own falling edge. The order of the data stream is the check.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  localparam int WORD_W = 18;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {SEL_EMPTY_OFS, SEL_FULL_OFS} ofs_sel_e;
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DEF_OFS = 7,
  localparam int OW     = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen,
  input  logic          ld,
  input  logic [OW-1:0] din_ofs,
  input  logic [AW:0]   rgray_s,
  output logic          wfire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull,
  output logic          hfull,
  output logic [OW-1:0] ae_ofs
);
  localparam logic [AW:0]   DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [OW-1:0] OFS_RST = OW'(DEF_OFS);

  logic [AW:0]   wbin_q, wbin_d, rbin_s, count, free;
  logic [OW-1:0] ae_q, ae_d, af_q, af_d;
  ofs_sel_e      sel_q, sel_d;

  for (genvar i = 0; i <= AW; i++) begin : g_g2b
    assign rbin_s[i] = ^(rgray_s >> i);
  end

  assign count = wbin_q - rbin_s;
  assign free  = DEPTH_V - count;
  assign full  = (count == DEPTH_V);
  assign afull = (free <= af_q);
  assign hfull = (count > (DEPTH_V >> 1));
  assign wfire = wen && !ld && !full;
  assign waddr = wbin_q[AW-1:0];
  assign ae_ofs = ae_q;

  always_comb begin
    wbin_d = wbin_q;
    if (wfire) wbin_d = wbin_q + 1'b1;
    sel_d = sel_q;
    ae_d  = ae_q;
    af_d  = af_q;
    if (!ld) begin
      sel_d = SEL_EMPTY_OFS;
    end else if (wen) begin
      if (sel_q == SEL_EMPTY_OFS) begin
        ae_d  = din_ofs;
        sel_d = SEL_FULL_OFS;
      end else begin
        af_d  = din_ofs;
        sel_d = SEL_EMPTY_OFS;
      end
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
      sel_q  <= SEL_EMPTY_OFS;
      ae_q   <= OFS_RST;
      af_q   <= OFS_RST;
    end else begin
      wbin_q <= wbin_d;
      wgray  <= wbin_d ^ (wbin_d >> 1);
      sel_q  <= sel_d;
      ae_q   <= ae_d;
      af_q   <= af_d;
    end
  end

  // R4
  wr_full_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && wen) |=> $stable(wbin_q));
  // R8
  wr_load_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    ld |=> $stable(wbin_q));
  // R7
  wr_full_af_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> afull);
  // R11
  wr_gray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int AW  = 4,
  localparam int OW = AW + 1
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  input  logic [AW:0]   wgray_s,
  input  logic [OW-1:0] ae_ofs,
  output logic          rfire,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          aempty
);
  logic [AW:0] rbin_q, rbin_d, wbin_s, count;

  for (genvar i = 0; i <= AW; i++) begin : g_g2b
    assign wbin_s[i] = ^(wgray_s >> i);
  end

  assign count  = wbin_s - rbin_q;
  assign empty  = (count == '0);
  assign aempty = (count <= ae_ofs);
  assign rfire  = ren && !empty;
  assign raddr  = rbin_q[AW-1:0];

  always_comb begin
    rbin_d = rbin_q;
    if (rfire) rbin_d = rbin_q + 1'b1;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
    end else begin
      rbin_q <= rbin_d;
      rgray  <= rbin_d ^ (rbin_d >> 1);
    end
  end

  // R4
  rd_empty_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && ren) |=> $stable(rbin_q));
  // R6
  rd_empty_ae_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> aempty);
  // R11
  rd_gray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
  import fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DEF_OFS = 7
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        rst_n,
  input  logic        wen,
  input  logic        ld,
  input  logic [17:0] din,
  input  logic        ren,
  input  logic        oe,
  output logic [17:0] dout,
  output logic        empty,
  output logic        almost_empty,
  output logic        full,
  output logic        almost_full,
  output logic        half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;

  logic          wrst_n, rrst_n, wfire, rfire;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [OW-1:0] ae_ofs;
  word_t         mem [DEPTH];
  word_t         q_q;

  fifo_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  fifo_gray_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  fifo_gray_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  fifo_wr_ctl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .ld(ld), .din_ofs(din[OW-1:0]),
    .rgray_s(rgray_s), .wfire(wfire), .waddr(waddr), .wgray(wgray),
    .full(full), .afull(almost_full), .hfull(half_full), .ae_ofs(ae_ofs));

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .wgray_s(wgray_s), .ae_ofs(ae_ofs),
    .rfire(rfire), .raddr(raddr), .rgray(rgray), .empty(empty), .aempty(almost_empty));

  always_ff @(posedge wclk) begin
    if (wfire) mem[waddr] <= din;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)    q_q <= '0;
    else if (rfire) q_q <= mem[raddr];
  end

  assign dout = oe ? q_q : '0;

  // R10
  oe_gate_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !oe |-> (dout == '0));
endmodule

// File: tb/dcfifo_top_tb.sv
module dcfifo_top_tb;
  logic clk = 1'b0, aclk = 1'b0, amode = 1'b0;
  logic rclk, rst_n, wen, ld, ren, oe;
  logic [17:0] din, dout;
  logic empty, almost_empty, full, almost_full, half_full;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always #13 aclk = ~aclk;
  assign rclk = amode ? aclk : clk;

  dcfifo_top u_dut (.wclk(clk), .rclk(rclk), .rst_n(rst_n), .wen(wen), .ld(ld),
    .din(din), .ren(ren), .oe(oe), .dout(dout), .empty(empty),
    .almost_empty(almost_empty), .full(full), .almost_full(almost_full),
    .half_full(half_full));

  function automatic logic [17:0] word(input int i);
    return 18'(i * 4993 + 11);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [17:0] w);
    @(negedge clk); wen = 1'b1; din = w;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); ren = 1'b1;
    @(negedge clk); ren = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(4);
  endtask

  // Fill n words from base, checking write-side flags at once and read-side flags after sync.
  task automatic fill(input int n, input int base, input int aeo, input int afo);
    for (int k = 1; k <= n; k++) begin
      wr(word(base + k - 1));
      check(full == (k == 16), "R3 full", full, k == 16);
      check(half_full == (k > 8), "R5 half_full", half_full, k > 8);
      check(almost_full == (16 - k <= afo), "R7 almost_full", almost_full, 16 - k <= afo);
      idle(2);
      check(empty == 1'b0, "R2 empty", empty, 0);
      check(almost_empty == (k <= aeo), "R6 almost_empty", almost_empty, k <= aeo);
    end
  endtask

  task automatic drain(input int n, input int base, input int aeo, input int afo);
    for (int k = 1; k <= n; k++) begin
      rd();
      check(dout == word(base + k - 1), "R1 data order", dout, word(base + k - 1));
      check(empty == (k == n), "R2 empty", empty, k == n);
      check(almost_empty == (n - k <= aeo), "R6 almost_empty", almost_empty, n - k <= aeo);
      idle(2);
      check(full == 1'b0, "R3 full", full, 0);
      check(half_full == (n - k > 8), "R5 half_full", half_full, n - k > 8);
      check(almost_full == (16 - (n - k) <= afo), "R7 almost_full", almost_full,
            16 - (n - k) <= afo);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wen = 0; ld = 0; ren = 0; oe = 1; din = '0;
    do_reset();
    // R9 reset state
    check(empty && almost_empty && !full && !almost_full && !half_full, "R9 flags", empty, 1);
    check(dout == '0, "R9 dout", dout, 0);

    fill(16, 0, 7, 7);
    wr(18'h3ffff);
    check(full == 1'b1, "R4 write while full", full, 1);
    drain(16, 0, 7, 7);

    rd();
    check(dout == word(15), "R4 read while empty keeps dout", dout, word(15));
    check(empty == 1'b1, "R4 empty stays", empty, 1);
    wr(18'h2a5a5); idle(2); rd();
    check(dout == 18'h2a5a5, "R4 pointers unmoved", dout, 18'h2a5a5);

    // R10 output enable
    @(negedge clk); oe = 1'b0; #1;
    check(dout == '0, "R10 oe low", dout, 0);
    @(negedge clk); oe = 1'b1; #1;
    check(dout == 18'h2a5a5, "R10 oe high", dout, 18'h2a5a5);

    // R8 load empty-side 3, full-side 12
    ld = 1'b1; wr(18'd3); wr(18'd12); ld = 1'b0; idle(3);
    check(empty == 1'b1, "R8 load suppresses write", empty, 1);
    fill(16, 100, 3, 12);
    drain(16, 100, 3, 12);

    // R8 wrap: third word overwrites empty-side offset
    ld = 1'b1; wr(18'd5); wr(18'd10); wr(18'd2); ld = 1'b0; idle(3);
    check(empty == 1'b1, "R8 load suppresses write", empty, 1);
    fill(6, 200, 2, 10);
    drain(6, 200, 2, 10);

    // R9 reset restores defaults mid-stream
    wr(word(7)); wr(word(8)); idle(1);
    do_reset();
    check(empty == 1'b1, "R9 empty after reset", empty, 1);
    check(dout == '0, "R9 dout after reset", dout, 0);
    fill(9, 300, 7, 7);

    // R11 asynchronous read clock
    rst_n = 1'b0; amode = 1'b1; idle(3); rst_n = 1'b1; idle(6);
    fork
      begin : writer
        int k = 0;
        while (k < 60) begin
          @(negedge clk);
          if (!full) begin wen = 1'b1; din = word(500 + k); k++; end
          else wen = 1'b0;
        end
        @(negedge clk); wen = 1'b0;
      end
      begin : reader
        int j = 0;
        int issued = 0;
        bit pend = 1'b0;
        while (j < 60) begin
          @(negedge aclk);
          if (pend) begin
            check(dout == word(500 + j), "R11 async order", dout, word(500 + j));
            j++;
          end
          ren  = !empty && (issued < 60);
          pend = ren;
          if (ren) issued++;
        end
        ren = 1'b0;
      end
    join
    repeat (4) @(negedge aclk);
    check(empty == 1'b1, "R11 drained", empty, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule